// File: doc/BRIEF.md
# Link Mode Agreement Checker

This block audits whether the link mode the MAC has latched matches what the PHY actually negotiated. When software or a link-up event pulses `start` while the MAC reports the link as up, the block reads three PHY management registers through a simple request/acknowledge port: the basic status register, the local ability advertisement and the partner ability. It ANDs the two ability words, picks the best mode they share by a fixed priority, and compares that two-bit code with the MAC's speed and duplex bits.

When the two views disagree, the block reads the PHY control register, sets the restart-negotiation bit while keeping every other bit, and writes the word back. It then waits for a settle interval derived from the clock frequency before it pulses `done` with `mismatch` raised. In all other cases it finishes early with `mismatch` low. The bit-serial management protocol and the MAC configuration sit outside this block.

Top module: `linkmode_audit`

## Requirements
- R1: A `start` accepted while `mac_link` is low makes no management access and pulses `done` in the next cycle with `mismatch` low.
- R2: The first access reads register 1. If bit 2 of that value (PHY link up) is clear, the run ends with `done` right after that read, with no further access and `mismatch` low.
- R3: With the PHY link up, the block next reads register 4 and then register 5, and forms the common ability as their bitwise AND.
- R4: Ability bits are 10 half duplex at bit 5, 10 full duplex at bit 6, 100 half duplex at bit 7 and 100 full duplex at bit 8. The resolved mode is the highest of 100FD, 100HD, 10FD, 10HD present in the common ability, coded 3, 1, 2 and 0 (code bit 0 = 100 Mb/s, code bit 1 = full duplex).
- R5: If the common ability holds none of the four mode bits, the run ends with `done` right after the register 5 read, with `mismatch` low.
- R6: `mac_mode` is captured when `start` is accepted. If it equals the resolved code, the run ends with `done` right after the register 5 read, with `mismatch` low. Later changes of `mac_mode` have no effect on the run.
- R7: If the codes differ, the block reads register 0 and then writes register 0 with the read value OR bit 9, all other bits unchanged. `mismatch` is high when `done` pulses.
- R8: After the register 0 write is acknowledged, `done` pulses exactly SETTLE_CYCLES = CLK_HZ / 1,000,000 x SETTLE_US cycles later.
- R9: `busy` is high from the cycle after `start` is accepted until the cycle in which `done` pulses. `done` is a single-cycle pulse. `mgmt_req` is only high while `busy` is high. A `start` that arrives while `busy` is high is ignored.
- R10: Once raised, `mgmt_req` stays high with `mgmt_wr`, `mgmt_addr` and `mgmt_wdata` unchanged until `mgmt_ack` is seen. Read data is taken only in the cycle in which `mgmt_ack` is high.
- R11: After reset, `busy`, `done`, `mismatch` and `mgmt_req` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one audit run (taken only when idle) |
| mac_link | input | 1 | MAC sees link up |
| mac_mode | input | 2 | MAC mode: bit 0 = 100 Mb/s, bit 1 = full duplex |
| mgmt_req | output | 1 | Management access request, held until acknowledged |
| mgmt_wr | output | 1 | 1 = write, 0 = read |
| mgmt_addr | output | ADDR_W | PHY register number |
| mgmt_wdata | output | DATA_W | Write data (zero for reads) |
| mgmt_ack | input | 1 | One-cycle access completion |
| mgmt_rdata | input | DATA_W | Read data, valid with `mgmt_ack` |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| mismatch | output | 1 | Last run restarted negotiation |

## Verification
The bench builds the block with CLK_HZ = 2,000,000 and SETTLE_US = 10, so the settle interval is 20 cycles instead of the 1.25 million it takes at the default 125 MHz and 10 ms. That puts the whole restart path, including the exact cycle of the `done` pulse after the write, within reach of a per-cycle comparison. The management responder is run at latencies of one to three cycles. Across runs it serves every resolved mode, agreeing and disagreeing MAC codes, a PHY with its link down, ability words with no shared mode, and a second `start` issued in the middle of a run.

// File: rtl/lma_pkg.sv
package lma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_STAT,
    ST_RD_ADV,
    ST_RD_LPA,
    ST_RD_CTL,
    ST_WR_CTL,
    ST_SETTLE
  } lma_state_e;

  // PHY register numbers used by the audit sequence
  localparam int unsigned REG_CONTROL = 0;
  localparam int unsigned REG_STATUS  = 1;
  localparam int unsigned REG_ADVERT  = 4;
  localparam int unsigned REG_PARTNER = 5;

  // bit positions inside those registers
  localparam int unsigned BIT_PHY_LINK = 2;
  localparam int unsigned BIT_RESTART  = 9;
  localparam int unsigned ABIL_LSB     = 5;  // 10HD, 10FD, 100HD, 100FD upward

  // mode codes: bit 0 = 100 Mb/s, bit 1 = full duplex
  localparam logic [1:0] MODE_10HD  = 2'd0;
  localparam logic [1:0] MODE_100HD = 2'd1;
  localparam logic [1:0] MODE_10FD  = 2'd2;
  localparam logic [1:0] MODE_100FD = 2'd3;

  typedef struct packed {
    logic       found;
    logic [1:0] code;
  } lma_mode_t;

  // abil[0]=10HD abil[1]=10FD abil[2]=100HD abil[3]=100FD
  function automatic lma_mode_t pick_mode(input logic [3:0] abil);
    lma_mode_t m;
    m.found = 1'b1;
    if (abil[3])      m.code = MODE_100FD;
    else if (abil[2]) m.code = MODE_100HD;
    else if (abil[1]) m.code = MODE_10FD;
    else if (abil[0]) m.code = MODE_10HD;
    else begin
      m.found = 1'b0;
      m.code  = MODE_10HD;
    end
    return m;
  endfunction

  function automatic longint settle_cycles(input longint clk_hz, input longint us);
    longint c;
    c = (clk_hz / 64'd1000000) * us;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/lma_resolver.sv
module lma_resolver
  import lma_pkg::*;
(
  input  logic [3:0] adv_abil,
  input  logic [3:0] lpa_abil,
  output lma_mode_t  mode
);
  logic [3:0] common;

  assign common = adv_abil & lpa_abil;
  assign mode   = pick_mode(common);
endmodule

// File: rtl/lma_mgmt_drive.sv
module lma_mgmt_drive
  import lma_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  lma_state_e          state,
  input  logic [DATA_W-1:0]   ctl_shadow,
  output logic                req,
  output logic                wr,
  output logic [ADDR_W-1:0]   addr,
  output logic [DATA_W-1:0]   wdata
);
  always_comb begin
    req   = 1'b1;
    wr    = 1'b0;
    addr  = '0;
    wdata = '0;
    unique case (state)
      ST_RD_STAT: addr = ADDR_W'(REG_STATUS);
      ST_RD_ADV:  addr = ADDR_W'(REG_ADVERT);
      ST_RD_LPA:  addr = ADDR_W'(REG_PARTNER);
      ST_RD_CTL:  addr = ADDR_W'(REG_CONTROL);
      ST_WR_CTL: begin
        wr    = 1'b1;
        addr  = ADDR_W'(REG_CONTROL);
        wdata = ctl_shadow;
        wdata[BIT_RESTART] = 1'b1;
      end
      default: req = 1'b0;
    endcase
  end
endmodule

// File: rtl/lma_settle_timer.sv
module lma_settle_timer #(
  parameter longint CYCLES = 10,
  parameter int     CNT_W  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == CNT_W'(CYCLES - 1));
endmodule

// File: rtl/linkmode_audit.sv
module linkmode_audit
  import lma_pkg::*;
#(
  parameter int     ADDR_W    = 5,
  parameter int     DATA_W    = 16,
  parameter longint CLK_HZ    = 125000000,
  parameter longint SETTLE_US = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mac_link,
  input  logic [1:0]        mac_mode,
  output logic              mgmt_req,
  output logic              mgmt_wr,
  output logic [ADDR_W-1:0] mgmt_addr,
  output logic [DATA_W-1:0] mgmt_wdata,
  input  logic              mgmt_ack,
  input  logic [DATA_W-1:0] mgmt_rdata,
  output logic              busy,
  output logic              done,
  output logic              mismatch
);
  localparam longint SETTLE_CYCLES = settle_cycles(CLK_HZ, SETTLE_US);
  localparam int     SETTLE_W      = $clog2(SETTLE_CYCLES + 1);

  lma_state_e        state;
  logic [1:0]        mac_mode_q;
  logic [3:0]        adv_abil_q;
  logic [DATA_W-1:0] ctl_q;
  logic              done_q;
  logic              mismatch_q;

  // named internal events, observed by the checker
  logic      run_accept;
  logic      xfer_fire;
  logic      restart_fire;
  logic      settle_over;
  lma_mode_t resolved;

  assign run_accept   = start && (state == ST_IDLE);
  assign xfer_fire    = mgmt_req && mgmt_ack;
  assign restart_fire = xfer_fire && mgmt_wr;

  lma_resolver u_resolve (
    .adv_abil (adv_abil_q),
    .lpa_abil (mgmt_rdata[ABIL_LSB +: 4]),
    .mode     (resolved)
  );

  lma_mgmt_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
    .state      (state),
    .ctl_shadow (ctl_q),
    .req        (mgmt_req),
    .wr         (mgmt_wr),
    .addr       (mgmt_addr),
    .wdata      (mgmt_wdata)
  );

  lma_settle_timer #(.CYCLES(SETTLE_CYCLES), .CNT_W(SETTLE_W)) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (state == ST_SETTLE),
    .expired (settle_over)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      mac_mode_q <= '0;
      adv_abil_q <= '0;
      ctl_q      <= '0;
      done_q     <= 1'b0;
      mismatch_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (run_accept) begin
          mismatch_q <= 1'b0;
          mac_mode_q <= mac_mode;
          if (mac_link) state  <= ST_RD_STAT;
          else          done_q <= 1'b1;
        end
        ST_RD_STAT: if (xfer_fire) begin
          if (mgmt_rdata[BIT_PHY_LINK]) state <= ST_RD_ADV;
          else begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        ST_RD_ADV: if (xfer_fire) begin
          adv_abil_q <= mgmt_rdata[ABIL_LSB +: 4];
          state      <= ST_RD_LPA;
        end
        ST_RD_LPA: if (xfer_fire) begin
          if (!resolved.found || resolved.code == mac_mode_q) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            state <= ST_RD_CTL;
          end
        end
        ST_RD_CTL: if (xfer_fire) begin
          ctl_q <= mgmt_rdata;
          state <= ST_WR_CTL;
        end
        ST_WR_CTL: if (xfer_fire) state <= ST_SETTLE;
        ST_SETTLE: if (settle_over) begin
          state      <= ST_IDLE;
          done_q     <= 1'b1;
          mismatch_q <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign done     = done_q;
  assign mismatch = mismatch_q;
endmodule

// File: rtl/lma_audit_chk.sv
module lma_audit_chk #(
  parameter int     ADDR_W        = 5,
  parameter int     DATA_W        = 16,
  parameter longint SETTLE_CYCLES = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mac_link,
  input logic              run_accept,
  input logic              restart_fire,
  input logic              mgmt_req,
  input logic              mgmt_ack,
  input logic              mgmt_wr,
  input logic [ADDR_W-1:0] mgmt_addr,
  input logic [DATA_W-1:0] mgmt_wdata,
  input logic              busy,
  input logic              done,
  input logic              mismatch
);
  localparam int SW = $clog2(SETTLE_CYCLES + 2) + 1;

  logic          wr_seen;
  logic [SW-1:0] since_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_seen  <= 1'b0;
      since_wr <= '1;
    end else begin
      if (run_accept)        wr_seen <= 1'b0;
      else if (restart_fire) wr_seen <= 1'b1;
      if (restart_fire)          since_wr <= '0;
      else if (since_wr != '1)   since_wr <= since_wr + 1'b1;
    end
  end

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_req |-> busy); // R9
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_req && !mgmt_ack |=> mgmt_req && $stable(mgmt_wr) && $stable(mgmt_addr) && $stable(mgmt_wdata)); // R10
  AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_req && mgmt_wr |-> (mgmt_addr == '0) && mgmt_wdata[9]); // R7
  AST_MISMATCH_WROTE: assert property (@(posedge clk) disable iff (!rst_n)
    done && mismatch |-> wr_seen); // R7
  AST_SETTLE_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    done && mismatch |-> since_wr == SW'(SETTLE_CYCLES)); // R8
  AST_MAC_DOWN_QUICK: assert property (@(posedge clk) disable iff (!rst_n)
    run_accept && !mac_link |=> done && !mismatch && !mgmt_req); // R1
endmodule

bind linkmode_audit lma_audit_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETTLE_CYCLES(SETTLE_CYCLES)
) u_audit_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mac_link     (mac_link),
  .run_accept   (run_accept),
  .restart_fire (restart_fire),
  .mgmt_req     (mgmt_req),
  .mgmt_ack     (mgmt_ack),
  .mgmt_wr      (mgmt_wr),
  .mgmt_addr    (mgmt_addr),
  .mgmt_wdata   (mgmt_wdata),
  .busy         (busy),
  .done         (done),
  .mismatch     (mismatch)
);

// File: tb/linkmode_audit_test.sv
module linkmode_audit_test;
  localparam longint CLK_HZ    = 2000000;
  localparam longint SETTLE_US = 10;
  localparam int     SETTLE    = 20;   // 2 cycles per us x 10 us
  localparam int     NEVER     = 32'h7fffffff;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic        mac_link = 0;
  logic [1:0]  mac_mode = 0;
  logic        mgmt_req, mgmt_wr;
  logic [4:0]  mgmt_addr;
  logic [15:0] mgmt_wdata;
  logic        mgmt_ack = 0;
  logic [15:0] mgmt_rdata = 16'hA5A5;
  logic        busy, done, mismatch;

  linkmode_audit #(.CLK_HZ(CLK_HZ), .SETTLE_US(SETTLE_US)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mac_link(mac_link), .mac_mode(mac_mode),
    .mgmt_req(mgmt_req), .mgmt_wr(mgmt_wr), .mgmt_addr(mgmt_addr), .mgmt_wdata(mgmt_wdata),
    .mgmt_ack(mgmt_ack), .mgmt_rdata(mgmt_rdata),
    .busy(busy), .done(done), .mismatch(mismatch)
  );

  always #4 clk = ~clk;  // 125 MHz

  int tests = 0, fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // PHY register image and responder state
  logic [15:0] r_stat, r_adv, r_lpa, r_ctl;
  int lat = 1, cnt = 0, n_ack = 0, exp_n = 0;
  bit serving = 0, exp_settle = 0;
  int start_edge = 0, exp_done_at = -1, cyc_err = 0;
  logic [21:0] exp_q[$], act_q[$];

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // management responder, latency lat, one-cycle ack (R10)
  always @(negedge clk) begin
    if (mgmt_ack) begin
      mgmt_ack   = 0;
      mgmt_rdata = 16'hA5A5;
    end else if (serving) begin
      if (cnt > 1) cnt--;
      else begin
        serving = 0;
        mgmt_ack = 1;
        act_q.push_back({mgmt_wr, mgmt_addr, mgmt_wr ? mgmt_wdata : 16'h0});
        if (mgmt_wr) begin
          if (mgmt_addr == 0) r_ctl = mgmt_wdata;
        end else begin
          case (mgmt_addr)
            5'd0: mgmt_rdata = r_ctl;
            5'd1: mgmt_rdata = r_stat;
            5'd4: mgmt_rdata = r_adv;
            5'd5: mgmt_rdata = r_lpa;
            default: mgmt_rdata = 16'h0;
          endcase
        end
        n_ack++;
        if (n_ack == exp_n) exp_done_at = cyc + 1 + (exp_settle ? SETTLE : 0);
      end
    end else if (mgmt_req) begin
      serving = 1;
      cnt = lat;
    end
  end

  // per-cycle reference comparison of done and busy (R9)
  always @(negedge clk) begin
    if (rst_n) begin
      if (done !== (cyc == exp_done_at)) cyc_err++;
      if (busy !== (cyc >= start_edge && cyc < exp_done_at)) cyc_err++;
    end
  end

  // behavioural model of one run: expected accesses and outcome
  function automatic bit model(input bit link, input logic [1:0] mm, input logic [15:0] st,
                               input logic [15:0] adv, input logic [15:0] lpa, input logic [15:0] ctl);
    logic [15:0] both;
    int code;
    exp_q.delete();
    exp_settle = 0;
    if (!link) return 0;
    exp_q.push_back({1'b0, 5'd1, 16'h0});
    if ((st & 16'h0004) == 0) return 0;
    exp_q.push_back({1'b0, 5'd4, 16'h0});
    exp_q.push_back({1'b0, 5'd5, 16'h0});
    both = adv & lpa;
    if (both[8]) code = 3;
    else if (both[7]) code = 1;
    else if (both[6]) code = 2;
    else if (both[5]) code = 0;
    else return 0;
    if (code == int'(mm)) return 0;
    exp_q.push_back({1'b0, 5'd0, 16'h0});
    exp_q.push_back({1'b1, 5'd0, ctl | 16'h0200});
    exp_settle = 1;
    return 1;
  endfunction

  task automatic run(input string req, input bit link, input logic [1:0] mm,
                     input logic [15:0] st, input logic [15:0] adv, input logic [15:0] lpa,
                     input logic [15:0] ctl, input int latency, input bit poke);
    bit exp_mis;
    int k;
    r_stat = st; r_adv = adv; r_lpa = lpa; r_ctl = ctl; lat = latency;
    exp_mis = model(link, mm, st, adv, lpa, ctl);
    exp_n = exp_q.size();
    act_q.delete();
    n_ack = 0;
    cyc_err = 0;
    @(negedge clk);
    mac_link = link; mac_mode = mm; start = 1;
    start_edge = cyc + 1;
    exp_done_at = (exp_n == 0) ? cyc + 1 : NEVER;
    @(negedge clk);
    start = 0;
    mac_mode = ~mm;            // later changes must not matter (R6)
    if (poke) begin            // second start mid-run is ignored (R9)
      repeat (3) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    k = 0;
    while (!done && k < 400) begin
      @(negedge clk);
      k++;
    end
    @(negedge clk);
    check(act_q.size() == exp_q.size(), req, "access count", act_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < act_q.size(); i++)
      check(act_q[i] == exp_q[i], req, "access content", int'(act_q[i]), int'(exp_q[i]));
    check(mismatch == exp_mis, req, "mismatch flag", int'(mismatch), int'(exp_mis));
    check(cyc_err == 0, req, "done/busy timing (R9, R8)", cyc_err, 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check(busy == 0 && done == 0 && mismatch == 0 && mgmt_req == 0, "R11", "reset outputs",
          {busy, done, mismatch, mgmt_req}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(busy == 0 && done == 0 && mgmt_req == 0, "R11", "idle after reset",
          {busy, done, mgmt_req}, 0);
    // R1: MAC link down
    run("R1", 0, 2'd3, 16'h782D, 16'h01E1, 16'h41E1, 16'h1000, 1, 0);
    // R2: PHY link bit clear
    run("R2", 1, 2'd3, 16'h7809, 16'h01E1, 16'h41E1, 16'h1000, 2, 0);
    // R3/R4/R6: 100FD shared, MAC agrees
    run("R6", 1, 2'd3, 16'h782D, 16'h01E1, 16'h41E1, 16'h1000, 1, 0);
    // R7/R8: 100FD shared, MAC says 100HD
    run("R7", 1, 2'd1, 16'h782D, 16'h01E1, 16'h41E1, 16'h1000, 2, 0);
    // R4: only 100HD shared, MAC says 100FD -> restart keeps other control bits
    run("R4", 1, 2'd3, 16'h782D, 16'h00A1, 16'h0181, 16'h3100, 3, 0);
    // R4: 10FD shared, MAC agrees
    run("R4", 1, 2'd2, 16'h782D, 16'h0061, 16'h0141, 16'h1000, 1, 0);
    // R4: 10HD only, MAC agrees
    run("R4", 1, 2'd0, 16'h782D, 16'h0021, 16'h01A1, 16'h1000, 2, 0);
    // R8: 10HD only, MAC says 10FD, restart bit already set
    run("R8", 1, 2'd2, 16'h782D, 16'h0021, 16'h01A1, 16'h1200, 1, 0);
    // R5: no shared mode
    run("R5", 1, 2'd3, 16'h782D, 16'h0041, 16'h01A1, 16'h1000, 1, 0);
    // R3: AND matters: partner 100FD only, local lacks it -> 10FD chosen
    run("R3", 1, 2'd3, 16'h782D, 16'h0061, 16'h0141, 16'h0000, 2, 0);
    // R9: extra start mid-run ignored
    run("R9", 1, 2'd0, 16'h782D, 16'h01E1, 16'h01E1, 16'h1140, 3, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule